// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block takes one fast master clock and derives two divided clocks, an A clock and a C clock. Each has its own even divide ratio and a 50% duty cycle. The C clock leaves the block as several copies. Some of the copies can be flipped by an invert control, which gives a clock shifted by 180 degrees. Neither ratio needs to be a multiple of the other. For that reason the block also drives an active-low marker, `sync_n`, that announces each master cycle in which the rising edges of A and C fall together.

The two ratios and the coincidence period are captured while reset is high. After reset releases, both divided clocks rise on the first master cycle. From then on, coincidences recur every LCM(Na, Nc) master cycles. Before each coincidence, `sync_n` goes low for one period of the faster divided clock and returns high in the coincidence cycle itself. Its rising edge therefore lines up with the common rising edge of A and C. Every output is a register, so `sync_n` cannot glitch.

Top module: `ces_sync_gen`

## Requirements
- R1: While `rst` is sampled high, `clk_a` and every bit of `clk_c` are 0 after the edge, and `sync_n` is 1.
- R2: In the first master cycle after reset releases, `clk_a` and `clk_c[0]` are both 1 and `sync_n` is 1. This is the first coincidence, and no pulse comes before it.
- R3: Counting t from 0 at that first cycle, `clk_a` is 1 exactly when (t mod Na) < Na/2. `clk_c[1:0]` are each 1 exactly when (t mod Nc) < Nc/2.
- R4: A raw ratio input (5 bits) is made even by clearing bit 0. The result is then clamped to the range 2 to 16. For example, 3 becomes 2, 0 becomes 2, 17 becomes 16, 31 becomes 16, and 9 becomes 8.
- R5: The ratio inputs are sampled only while `rst` is high. Changes to them at any other time have no effect on any output.
- R6: With unequal ratios, and L = LCM(Na, Nc), M = min(Na, Nc): `sync_n` is 0 exactly when (t mod L) ≥ L−M. Each low interval therefore lasts M master cycles, and `sync_n` rises in a cycle where both `clk_a` and `clk_c[0]` rise.
- R7: With equal ratios N, `sync_n` is 0 for N−1 cycles and 1 only in each coincidence cycle (t mod N = 0).
- R8: Every coincidence after the first one is preceded by exactly one low interval of `sync_n`. There is no other low interval.
- R9: `clk_c[3:2]` equal `clk_c[0]` XOR the value of `inv_c` sampled at the same edge. So a change of `inv_c` shows one cycle later. `inv_c` has no effect on `clk_c[1:0]`, `clk_a` or `sync_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; ratios are captured while high |
| div_a | input | 5 | Raw divide ratio for the A clock |
| div_c | input | 5 | Raw divide ratio for the C clock |
| inv_c | input | 1 | Inverts the invertible C copies |
| clk_a | output | 1 | Divided A clock |
| clk_c | output | 4 | C clock copies; [1:0] normal, [3:2] invertible |
| sync_n | output | 1 | Active-low pulse before each A/C coincidence |

## Verification
The bench builds the block with its default configuration: a ratio ceiling of 16, four C copies, and the top two of those invertible. With these settings every even ratio pair is reachable, up to a coincidence period of 112 master cycles for the 16/14 pair. The bench runs the equal-ratio and integer-multiple pairs, swaps which clock is faster, and feeds raw ratios that must be rounded or clamped. During each run it toggles the invert control and scrambles the ratio inputs after reset.

// File: rtl/ces_pkg.sv
`timescale 1ns/1ps
package ces_pkg;
    localparam int DIV_W   = 5;
    localparam int MIN_DIV = 2;
    localparam int MAX_DIV = 16;
    localparam int LCM_W   = 8;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [LCM_W-1:0] lcm_t;

    // captured divider configuration
    typedef struct packed {
        div_t ratio;
        div_t half;
    } div_cfg_t;

    // captured coincidence-window configuration
    typedef struct packed {
        lcm_t period;
        lcm_t win_start;
    } win_cfg_t;

    function automatic div_t fix_ratio(div_t raw);
        div_t v;
        v = {raw[DIV_W-1:1], 1'b0};
        if (v < div_t'(MIN_DIV))
            v = div_t'(MIN_DIV);
        else if (v > div_t'(MAX_DIV))
            v = div_t'(MAX_DIV);
        return v;
    endfunction

    function automatic div_t min_ratio(div_t a, div_t b);
        return (a < b) ? a : b;
    endfunction

    // smallest multiple of a that b divides; descending scan keeps the least
    function automatic lcm_t lcm_of(div_t a, div_t b);
        int   ai;
        int   bi;
        lcm_t r;
        ai = int'(a);
        bi = int'(b);
        r  = lcm_t'(ai);
        for (int k = MAX_DIV; k >= 1; k--) begin
            if (((ai * k) % bi) == 0)
                r = lcm_t'(ai * k);
        end
        return r;
    endfunction
endpackage

// File: rtl/ces_divider.sv
`timescale 1ns/1ps
module ces_divider
    import ces_pkg::*;
#(
    parameter int N_OUT = 1,
    parameter int N_INV = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  div_t             ratio_in,
    input  logic             inv,
    output logic [N_OUT-1:0] q
);
    localparam int FIRST_INV = N_OUT - N_INV;

    div_cfg_t         cfg_q;
    div_cfg_t         cfg_new;
    div_t             cnt_q;
    div_t             cnt_nxt;
    logic             phase_hi;
    logic [N_OUT-1:0] q_nxt;

    always_comb begin
        cfg_new.ratio = fix_ratio(ratio_in);
        cfg_new.half  = cfg_new.ratio >> 1;
    end

    assign cnt_nxt  = (cnt_q >= cfg_q.ratio - 1'b1) ? '0 : cnt_q + 1'b1;
    assign phase_hi = (cnt_nxt < cfg_q.half);

    for (genvar i = 0; i < N_OUT; i++) begin : g_copy
        if (i >= FIRST_INV) begin : g_inv
            assign q_nxt[i] = phase_hi ^ inv;
        end else begin : g_plain
            assign q_nxt[i] = phase_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_new;
            cnt_q <= cfg_new.ratio - 1'b1;
            q     <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            q     <= q_nxt;
        end
    end
endmodule

// File: rtl/ces_sync_window.sv
`timescale 1ns/1ps
module ces_sync_window
    import ces_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  div_t ratio_a_in,
    input  div_t ratio_c_in,
    output logic sync_n
);
    win_cfg_t cfg_q;
    win_cfg_t cfg_new;
    div_t     ra;
    div_t     rc;
    lcm_t     cnt_q;
    lcm_t     cnt_nxt;
    logic     in_window;

    always_comb begin
        ra                = fix_ratio(ratio_a_in);
        rc                = fix_ratio(ratio_c_in);
        cfg_new.period    = lcm_of(ra, rc);
        cfg_new.win_start = cfg_new.period - lcm_t'(min_ratio(ra, rc));
    end

    assign cnt_nxt   = (cnt_q >= cfg_q.period - 1'b1) ? '0 : cnt_q + 1'b1;
    // the coincidence cycle itself is never inside the window
    assign in_window = (cnt_nxt != '0) && (cnt_nxt >= cfg_q.win_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= cfg_new;
            cnt_q  <= cfg_new.period - 1'b1;
            sync_n <= 1'b1;
        end else begin
            cnt_q  <= cnt_nxt;
            sync_n <= !in_window;
        end
    end
endmodule

// File: rtl/ces_sync_gen.sv
`timescale 1ns/1ps
module ces_sync_gen
    import ces_pkg::*;
#(
    parameter int N_C_OUT = 4,
    parameter int N_C_INV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   div_a,
    input  logic [DIV_W-1:0]   div_c,
    input  logic               inv_c,
    output logic               clk_a,
    output logic [N_C_OUT-1:0] clk_c,
    output logic               sync_n
);
    logic [0:0] a_bus;

    ces_divider #(.N_OUT(1), .N_INV(0)) u_div_a (
        .clk      (clk),
        .rst      (rst),
        .ratio_in (div_a),
        .inv      (1'b0),
        .q        (a_bus)
    );

    ces_divider #(.N_OUT(N_C_OUT), .N_INV(N_C_INV)) u_div_c (
        .clk      (clk),
        .rst      (rst),
        .ratio_in (div_c),
        .inv      (inv_c),
        .q        (clk_c)
    );

    ces_sync_window u_win (
        .clk        (clk),
        .rst        (rst),
        .ratio_a_in (div_a),
        .ratio_c_in (div_c),
        .sync_n     (sync_n)
    );

    assign clk_a = a_bus[0];
endmodule

// File: rtl/ces_sync_gen_chk.sv
`timescale 1ns/1ps
module ces_sync_gen_chk
    import ces_pkg::*;
#(
    parameter int N_C_OUT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               inv_c,
    input logic               clk_a,
    input logic [N_C_OUT-1:0] clk_c,
    input logic               sync_n
);
    logic rst_q  = 1'b0;
    logic armed  = 1'b0;
    logic armed2 = 1'b0;
    int   low_run;
    int   hi_run_a;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        armed  <= !rst;
        armed2 <= armed && !rst;
        if (rst) begin
            low_run  <= 0;
            hi_run_a <= 0;
        end else begin
            low_run  <= sync_n ? 0 : low_run + 1;
            hi_run_a <= clk_a ? hi_run_a + 1 : 0;
        end
    end

    // R1: outputs written by a reset edge hold their idle values
    always @(posedge clk) begin
        if (rst_q) begin
            a_reset_state_r1: assert (clk_a == 1'b0 && clk_c == '0 && sync_n == 1'b1)
                else $error("reset state wrong");
        end
    end

    // R6: the end of a sync pulse coincides with both clocks rising
    p_rise_on_coincidence_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> ($rose(clk_a) && $rose(clk_c[0])));

    // R8: every coincidence after the first is announced
    p_coincidence_announced_r8: assert property (@(posedge clk) disable iff (rst)
        (armed2 && $rose(clk_a) && $rose(clk_c[0])) |-> $rose(sync_n));

    // R6/R7: low interval is at least one and at most one slow period
    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (low_run >= 1 && low_run <= MAX_DIV));

    // R3: high phase of A never exceeds half the largest ratio
    p_half_high_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_a) |-> (hi_run_a >= 1 && hi_run_a <= MAX_DIV / 2));

    // R9: invertible copies follow the registered invert control
    p_inverted_copy_r9: assert property (@(posedge clk) disable iff (rst)
        armed |-> (clk_c[2] == (clk_c[0] ^ $past(inv_c)) && clk_c[3] == clk_c[2]
                   && clk_c[1] == clk_c[0]));
endmodule

bind ces_sync_gen ces_sync_gen_chk #(.N_C_OUT(N_C_OUT)) i_chk (
    .clk    (clk),
    .rst    (rst),
    .inv_c  (inv_c),
    .clk_a  (clk_a),
    .clk_c  (clk_c),
    .sync_n (sync_n)
);

// File: tb/test_ces_sync_gen.sv
`timescale 1ns/1ps
module test_ces_sync_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] div_a = 5'd4;
    logic [4:0] div_c = 5'd6;
    logic       inv_c = 1'b0;
    logic       clk_a;
    logic [3:0] clk_c;
    logic       sync_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // {raw_a, raw_c, expected Na, expected Nc, expected LCM}
    localparam int NV = 10;
    localparam int VEC [NV][5] = '{
        '{ 2,  2,  2,  2,   2},
        '{ 4,  6,  4,  6,  12},
        '{ 6,  4,  6,  4,  12},
        '{ 8,  2,  8,  2,   8},
        '{ 2,  8,  2,  8,   8},
        '{16, 14, 16, 14, 112},
        '{10,  6, 10,  6,  30},
        '{12, 12, 12, 12,  12},
        '{16, 16, 16, 16,  16},
        '{ 6, 10,  6, 10,  30}
    };

    ces_sync_gen i_ces_sync_gen (
        .clk    (clk),
        .rst    (rst),
        .div_a  (div_a),
        .div_c  (div_c),
        .inv_c  (inv_c),
        .clk_a  (clk_a),
        .clk_c  (clk_c),
        .sync_n (sync_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_pair(input int ra, input int rc, input int na, input int nc,
                            input int ln, input string tag);
        int m;
        int low_run;
        int pulses;
        int run_len;
        int inv_prev;
        int ph;
        int exp_a;
        int exp_c;
        int exp_s;
        m        = (na < nc) ? na : nc;
        low_run  = 0;
        pulses   = 0;
        run_len  = 2 * ln + 4;
        inv_prev = 0;
        @(negedge clk);
        rst   = 1'b1;
        div_a = 5'(ra);
        div_c = 5'(rc);
        inv_c = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: idle values after reset edges, even with inv_c high
        chk({tag, " R1 clk_a"},  int'(clk_a),  0);
        chk({tag, " R1 clk_c"},  int'(clk_c),  0);
        chk({tag, " R1 sync_n"}, int'(sync_n), 1);
        rst   = 1'b0;
        inv_c = 1'b0;
        // R5: scrambled ratio inputs after reset must be ignored
        div_a = ~5'(ra);
        div_c = ~5'(rc);
        for (int t = 0; t < run_len; t++) begin
            @(negedge clk);
            ph    = t % ln;
            exp_a = ((t % na) < na / 2) ? 1 : 0;
            exp_c = ((t % nc) < nc / 2) ? 1 : 0;
            exp_s = (ph != 0 && ph >= ln - m) ? 0 : 1;
            if (t == 0) begin
                chk({tag, " R2 first edge"}, int'(clk_a && clk_c[0] && sync_n), 1);
            end
            chk({tag, " R3/R5 clk_a"},   int'(clk_a),    exp_a);
            chk({tag, " R3/R5 clk_c0"},  int'(clk_c[0]), exp_c);
            chk({tag, " R3 clk_c1"},     int'(clk_c[1]), exp_c);
            chk({tag, " R9 clk_c2"},     int'(clk_c[2]), exp_c ^ inv_prev);
            chk({tag, " R9 clk_c3"},     int'(clk_c[3]), exp_c ^ inv_prev);
            chk({tag, (na == nc) ? " R7 sync_n" : " R6 sync_n"}, int'(sync_n), exp_s);
            if (!sync_n) begin
                low_run++;
            end else if (low_run > 0) begin
                chk({tag, (na == nc) ? " R7 width" : " R6 width"},
                    low_run, (na == nc) ? na - 1 : m);
                chk({tag, " R6 rise on coincidence"}, int'(clk_a && clk_c[0]), 1);
                pulses++;
                low_run = 0;
            end
            inv_prev = (t / 3) % 2;
            inv_c    = inv_prev[0];
        end
        // R8: one pulse per coincidence after the first
        chk({tag, " R8 pulse count"}, pulses, (run_len - 1) / ln);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // vector table
        for (int v = 0; v < NV; v++) begin
            run_pair(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], "vec");
        end
        // R4: raw ratios rounded and clamped
        run_pair( 3,  0,  2,  2,  2, "R4 low");
        run_pair(31, 17, 16, 16, 16, "R4 high");
        run_pair( 5,  9,  4,  8,  8, "R4 odd");
        run_pair(15, 12, 14, 12, 84, "R4 odd14");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule